// File: doc/BRIEF.md
# UART Register Bank with Banked Baud Divisor

This block is the byte-wide control-register front end of a UART-style serial controller. A host reaches it over a simple bus made of an offset, write data, read data, a write strobe and a read strobe. It holds line framing, modem control, interrupt-enable and receive-FIFO configuration state, and it drives that state onto plain ports. The serial shifters, the FIFOs and interrupt prioritisation sit outside the block and connect to those ports.

A 16-bit baud divisor shares its two byte offsets with the transmit/receive data register and the interrupt-enable register. A bank-select bit in the line-control register swaps which of the two sets the host reaches. From the divisor the block generates a one-cycle oversampling tick at the system clock divided by the divisor. This is 16 times the serial bit rate. Software programs a rate in four steps: set the bank bit, write the low byte, write the high byte, clear the bank bit. Every step leaves the other registers as they were.

Offsets: 0 data / divisor low, 1 interrupt enable / divisor high, 2 FIFO control, 3 line control, 4 modem control, 5 line status (read only), 6 and 7 read as zero.

Top module: `uart_regbank`

## Requirements
- R1: After reset, line control reads 0x03 (8 data bits, no parity, 1 stop bit). Interrupt enable, modem control, FIFO control and both divisor bytes read 0, and no baud tick occurs.
- R2: With line-control bit 7 set, offsets 0 and 1 read and write divisor low and high bytes. Writes there leave interrupt enable unchanged and raise no transmit push.
- R3: With line-control bit 7 clear, a write to offset 0 raises tx_push_o for exactly the next cycle with tx_byte_o equal to the written byte. A read of offset 0 returns rx_byte_i and raises rx_pop_o in the same cycle. Offset 1 holds interrupt enable in bits 3:0, and bits 7:4 read 0.
- R4: The divisor bytes keep their values across writes to every other register, including the bank-bit clear.
- R5: With divisor N > 0, baud_tick_o is a one-cycle pulse that repeats every N cycles.
- R6: With divisor 0, baud_tick_o stays low.
- R7: Writing either divisor byte reloads the tick counter. The first tick comes N-1 clock edges after the edge that captures the write.
- R8: At offset 2, write bit 0 is a stored FIFO enable and reads back in bit 0. Write bits 1 and 2 each raise rx_flush_o or tx_flush_o for exactly the next cycle and read back as 0.
- R9: Offset-2 bits 7:6 store a trigger code that reads back in place. rx_trig_level_o equals 1, 4, 8 or 14 for codes 0 to 3.
- R10: Offset 4 holds DTR in bit 0, RTS in bit 1 and loopback in bit 4, all readable and driven on ports. Its other bits read 0.
- R11: Line-control bits drive the framing ports: 1:0 word length code, 2 two stop bits, 3 parity enable, 4 even parity, 5 stick parity, 6 break.
- R12: Offset 5 reads line_status_i, and offsets 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data (combinational) |
| rx_byte_i | input | 8 | Head byte of the receive FIFO |
| line_status_i | input | 8 | Line status from the datapath |
| rx_pop_o | output | 1 | Receive FIFO pop on data read |
| tx_push_o | output | 1 | Transmit FIFO push |
| tx_byte_o | output | 8 | Byte to push |
| ien_o | output | 4 | Interrupt enables |
| word_len_o | output | 2 | Word length code |
| two_stop_o | output | 1 | Two stop bits |
| par_en_o | output | 1 | Parity enable |
| par_even_o | output | 1 | Even parity |
| par_stick_o | output | 1 | Stick parity |
| break_o | output | 1 | Force break |
| dtr_o | output | 1 | Data terminal ready |
| rts_o | output | 1 | Request to send |
| loop_o | output | 1 | Loopback enable |
| fifo_en_o | output | 1 | FIFO enable |
| rx_flush_o | output | 1 | Receive FIFO flush pulse |
| tx_flush_o | output | 1 | Transmit FIFO flush pulse |
| rx_trig_level_o | output | 4 | Receive trigger level in bytes |
| baud_tick_o | output | 1 | Oversampling tick |

## Verification
The hardest situation to reach from the ports is a divisor reload landing partway through a running count. The first tick after the reload must follow the new divisor, not the remains of the old count. The stimulus first runs a long divisor so that the counter is mid-period, then does the full bank-bit sequence with a short divisor. It measures the distance from the high-byte write to the first tick, and then the steady period. Randomized register writes with the bank bit toggling in between confirm that the divisor bytes and the registers sharing their offsets never disturb one another.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  typedef enum logic [2:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_FIFO  = 3'd2,
    OFS_LINE  = 3'd3,
    OFS_MODEM = 3'd4,
    OFS_STAT  = 3'd5
  } reg_ofs_e;

  typedef struct packed {
    logic thr;
    logic ien;
    logic dll;
    logic dlm;
    logic fcr;
    logic lcr;
    logic mcr;
  } wr_strobe_t;

  localparam int LCR_BANK_BIT = 7;
  localparam logic [7:0] LCR_RESET = 8'h03;

  function automatic logic [3:0] trig_bytes(input logic [1:0] code);
    case (code)
      2'd0:    trig_bytes = 4'd1;
      2'd1:    trig_bytes = 4'd4;
      2'd2:    trig_bytes = 4'd8;
      default: trig_bytes = 4'd14;
    endcase
  endfunction

endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              bank_i,
  output wr_strobe_t        ws_o
);

  always_comb begin
    ws_o     = '0;
    ws_o.thr = wr_i && (addr_i == ADDR_W'(OFS_DATA))  && !bank_i;
    ws_o.dll = wr_i && (addr_i == ADDR_W'(OFS_DATA))  &&  bank_i;
    ws_o.ien = wr_i && (addr_i == ADDR_W'(OFS_IEN))   && !bank_i;
    ws_o.dlm = wr_i && (addr_i == ADDR_W'(OFS_IEN))   &&  bank_i;
    ws_o.fcr = wr_i && (addr_i == ADDR_W'(OFS_FIFO));
    ws_o.lcr = wr_i && (addr_i == ADDR_W'(OFS_LINE));
    ws_o.mcr = wr_i && (addr_i == ADDR_W'(OFS_MODEM));
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ws_o)); // R2

endmodule

// File: rtl/uart_regbank_baudgen.sv
module uart_regbank_baudgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] load_val_i,
  output logic             tick_o
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign tick_o = (cnt_q == ONE);
  assign wrap   = tick_o && !load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (div_i == '0)     cnt_q <= '0;
    else if (cnt_q <= ONE)    cnt_q <= div_i;
    else                      cnt_q <= cnt_q - ONE;
  end

  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i == '0) |-> !tick_o); // R6

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == $past(div_i))); // R5

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i))); // R7

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int IEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic [DATA_W-1:0] line_status_i,
  output logic              rx_pop_o,
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic [IEN_W-1:0]  ien_o,
  output logic [1:0]        word_len_o,
  output logic              two_stop_o,
  output logic              par_en_o,
  output logic              par_even_o,
  output logic              par_stick_o,
  output logic              break_o,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              loop_o,
  output logic              fifo_en_o,
  output logic              rx_flush_o,
  output logic              tx_flush_o,
  output logic [3:0]        rx_trig_level_o,
  output logic              baud_tick_o
);

  localparam int DIV_W = 2 * DATA_W;

  logic [DATA_W-1:0] lcr_q, dll_q, dlm_q, tx_byte_q;
  logic [IEN_W-1:0]  ien_q;
  logic              dtr_q, rts_q, loop_q, fifo_en_q;
  logic [1:0]        trig_q;
  logic              tx_push_q, rx_flush_q, tx_flush_q;
  logic              bank;
  wr_strobe_t        ws;
  logic              div_load;
  logic [DIV_W-1:0]  div_next;

  assign bank = lcr_q[LCR_BANK_BIT];

  uart_regbank_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_i (bus_addr),
    .wr_i   (bus_wr),
    .bank_i (bank),
    .ws_o   (ws)
  );

  assign div_load = ws.dll || ws.dlm;
  assign div_next = {ws.dlm ? bus_wdata : dlm_q, ws.dll ? bus_wdata : dll_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q      <= LCR_RESET;
      dll_q      <= '0;
      dlm_q      <= '0;
      ien_q      <= '0;
      dtr_q      <= 1'b0;
      rts_q      <= 1'b0;
      loop_q     <= 1'b0;
      fifo_en_q  <= 1'b0;
      trig_q     <= '0;
      tx_byte_q  <= '0;
      tx_push_q  <= 1'b0;
      rx_flush_q <= 1'b0;
      tx_flush_q <= 1'b0;
    end else begin
      tx_push_q  <= ws.thr;
      rx_flush_q <= ws.fcr && bus_wdata[1];
      tx_flush_q <= ws.fcr && bus_wdata[2];
      if (ws.thr) tx_byte_q <= bus_wdata;
      if (ws.lcr) lcr_q <= bus_wdata;
      if (ws.dll) dll_q <= bus_wdata;
      if (ws.dlm) dlm_q <= bus_wdata;
      if (ws.ien) ien_q <= bus_wdata[IEN_W-1:0];
      if (ws.mcr) begin
        dtr_q  <= bus_wdata[0];
        rts_q  <= bus_wdata[1];
        loop_q <= bus_wdata[4];
      end
      if (ws.fcr) begin
        fifo_en_q <= bus_wdata[0];
        trig_q    <= bus_wdata[7:6];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_DATA):  bus_rdata = bank ? dll_q : rx_byte_i;
      ADDR_W'(OFS_IEN):   bus_rdata = bank ? dlm_q : DATA_W'(ien_q);
      ADDR_W'(OFS_FIFO):  bus_rdata = {trig_q, 5'b0, fifo_en_q};
      ADDR_W'(OFS_LINE):  bus_rdata = lcr_q;
      ADDR_W'(OFS_MODEM): bus_rdata = {3'b0, loop_q, 2'b0, rts_q, dtr_q};
      ADDR_W'(OFS_STAT):  bus_rdata = line_status_i;
      default:            bus_rdata = '0;
    endcase
  end

  uart_regbank_baudgen #(.DIV_W(DIV_W)) u_baud (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_i      ({dlm_q, dll_q}),
    .load_i     (div_load),
    .load_val_i (div_next),
    .tick_o     (baud_tick_o)
  );

  assign rx_pop_o        = bus_rd && (bus_addr == ADDR_W'(OFS_DATA)) && !bank;
  assign tx_push_o       = tx_push_q;
  assign tx_byte_o       = tx_byte_q;
  assign ien_o           = ien_q;
  assign word_len_o      = lcr_q[1:0];
  assign two_stop_o      = lcr_q[2];
  assign par_en_o        = lcr_q[3];
  assign par_even_o      = lcr_q[4];
  assign par_stick_o     = lcr_q[5];
  assign break_o         = lcr_q[6];
  assign dtr_o           = dtr_q;
  assign rts_o           = rts_q;
  assign loop_o          = loop_q;
  assign fifo_en_o       = fifo_en_q;
  assign rx_flush_o      = rx_flush_q;
  assign tx_flush_o      = tx_flush_q;
  assign rx_trig_level_o = trig_bytes(trig_q);

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !div_load |=> $stable({dlm_q, dll_q})); // R4

  AST_BANK_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bank && bus_addr == ADDR_W'(OFS_DATA)) |=> !tx_push_o); // R2

  AST_FLUSH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_o |-> $past(bus_wr && bus_addr == ADDR_W'(OFS_FIFO) && bus_wdata[1])); // R8

  AST_POP_UNBANKED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_o |-> !lcr_q[LCR_BANK_BIT]); // R3

endmodule

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] rx_byte_i = 8'hA5;
  logic [7:0] line_status_i = 8'h61;
  logic       rx_pop_o, tx_push_o;
  logic [7:0] tx_byte_o;
  logic [3:0] ien_o;
  logic [1:0] word_len_o;
  logic       two_stop_o, par_en_o, par_even_o, par_stick_o, break_o;
  logic       dtr_o, rts_o, loop_o, fifo_en_o, rx_flush_o, tx_flush_o;
  logic [3:0] rx_trig_level_o;
  logic       baud_tick_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_lcr, m_dll, m_dlm, m_ien, m_mcr, m_fcr;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regbank u_uart_regbank (.*);

  function automatic logic [3:0] exp_trig(input logic [1:0] c);
    logic [3:0] t [4] = '{4'd1, 4'd4, 4'd8, 4'd14};
    return t[c];
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    logic bk = m_lcr[7];
    case (a)
      3'd0: return bk ? m_dll : rx_byte_i;
      3'd1: return bk ? m_dlm : {4'h0, m_ien[3:0]};
      3'd2: return m_fcr & 8'hC1;
      3'd3: return m_lcr;
      3'd4: return m_mcr & 8'h13;
      3'd5: return line_status_i;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      3'd0: if (m_lcr[7]) m_dll = d;
      3'd1: if (m_lcr[7]) m_dlm = d; else m_ien = d;
      3'd2: m_fcr = d;
      3'd3: m_lcr = d;
      3'd4: m_mcr = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic pop);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata; pop = rx_pop_o;
    bus_rd = 1'b0;
  endtask

  task automatic set_div(input logic [15:0] n);
    wr(3'd3, m_lcr | 8'h80);
    wr(3'd0, n[7:0]);
    wr(3'd1, n[15:8]);
  endtask

  task automatic measure(input string req, input int n);
    int k = 0;
    while (baud_tick_o !== 1'b1 && k < n + 5) begin @(negedge clk); k++; end
    chk({req, " first tick delay"}, k, n - 1);
    @(negedge clk);
    k = 1;
    while (baud_tick_o !== 1'b1 && k < n + 5) begin @(negedge clk); k++; end
    chk("R5 tick period", k, n);
    @(negedge clk);
    chk("R5 tick one cycle", (n == 1) ? 1 : int'(baud_tick_o), (n == 1) ? 1 : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic p;
    int ticks;
    void'($urandom(32'd1234));
    m_lcr = 8'h03; m_dll = 0; m_dlm = 0; m_ien = 0; m_mcr = 0; m_fcr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      if (a == 0) continue;
      rd(3'(a), d, p); chk("R1 reset readback", d, exp_read(3'(a)));
    end
    chk("R1 lcr reset", {break_o, par_stick_o, par_even_o, par_en_o, two_stop_o, word_len_o}, 3);
    ticks = 0;
    repeat (40) begin @(negedge clk); ticks += baud_tick_o; end
    chk("R1 no tick after reset", ticks, 0);

    // R3 data path
    rd(3'd0, d, p);
    chk("R3 rx read", d, 8'hA5); chk("R3 rx pop", p, 1);
    wr(3'd0, 8'h3C);
    chk("R3 tx push", tx_push_o, 1); chk("R3 tx byte", tx_byte_o, 8'h3C);
    @(negedge clk); chk("R3 push one cycle", tx_push_o, 0);
    wr(3'd1, 8'hFB);
    rd(3'd1, d, p); chk("R3 ien readback", d, 8'h0B); chk("R3 ien port", ien_o, 4'hB);

    // R2 banked access
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h77);
    chk("R2 no push in bank", tx_push_o, 0);
    rd(3'd0, d, p); chk("R2 dll read", d, 8'h77); chk("R2 no pop in bank", p, 0);
    wr(3'd1, 8'h01);
    rd(3'd1, d, p); chk("R2 dlm read", d, 8'h01);
    wr(3'd3, 8'h03);
    chk("R2 ien untouched", ien_o, 4'hB);
    rd(3'd1, d, p); chk("R2 ien readback", d, 8'h0B);
    wr(3'd3, 8'h80);
    rd(3'd0, d, p); chk("R4 dll survives", d, 8'h77);
    rd(3'd1, d, p); chk("R4 dlm survives", d, 8'h01);
    wr(3'd3, 8'h03);

    // R8 / R9 FIFO control
    wr(3'd2, 8'hC7);
    chk("R8 rx flush", rx_flush_o, 1); chk("R8 tx flush", tx_flush_o, 1);
    @(negedge clk);
    chk("R8 rx flush clears", rx_flush_o, 0); chk("R8 tx flush clears", tx_flush_o, 0);
    rd(3'd2, d, p); chk("R8 fcr readback", d, 8'hC1); chk("R8 fifo en", fifo_en_o, 1);
    for (int c = 0; c < 4; c++) begin
      wr(3'd2, {2'(c), 6'd0});
      chk("R9 trigger level", rx_trig_level_o, exp_trig(2'(c)));
    end

    // R10 / R12
    wr(3'd4, 8'hFF);
    rd(3'd4, d, p); chk("R10 mcr readback", d, 8'h13);
    chk("R10 mcr ports", {loop_o, rts_o, dtr_o}, 3'b111);
    rd(3'd5, d, p); chk("R12 status", d, 8'h61);
    rd(3'd6, d, p); chk("R12 offset6", d, 0);
    rd(3'd7, d, p); chk("R12 offset7", d, 0);

    // R5 / R7 baud timing, including reload mid-count
    set_div(16'd5);  measure("R7", 5);
    wr(3'd3, 8'h03);
    set_div(16'd1);  measure("R7", 1);
    set_div(16'd300);
    repeat (120) @(negedge clk);
    set_div(16'd7);  measure("R7 reload mid-count", 7);
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h0A); measure("R7 low byte reload", 10);
    set_div(16'd0);
    ticks = 0;
    repeat (200) begin @(negedge clk); ticks += baud_tick_o; end
    chk("R6 stopped", ticks, 0);
    wr(3'd3, 8'h03);

    // random register traffic
    for (int i = 0; i < 300; i++) begin
      logic [2:0] a;
      logic [7:0] v;
      a = 3'($urandom_range(0, 4));
      v = 8'($urandom);
      if (a == 3'd3) v[7] = v[0];
      wr(a, v);
      chk("R11 word len", word_len_o, m_lcr[1:0]);
      chk("R11 framing", {break_o, par_stick_o, par_even_o, par_en_o, two_stop_o},
          m_lcr[6:2]);
      for (int r = 0; r < 5; r++) begin
        rd(3'(r), d, p);
        chk("R4 random readback", d, exp_read(3'(r)));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule